// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block holds an 8-bit accumulator and an 8-bit auxiliary operand register and runs five arithmetic operations on them: plain addition, addition with the incoming carry, subtraction with the incoming borrow, an 8x8 multiply and an 8/8 divide. Next to them sits an 8-bit status word. It records the carry, the nibble carry and the overflow of the last operation. It also holds two general-purpose software flags and two bank-select bits, and it shows a parity bit that follows the accumulator at all times.

Software reaches the status word in two ways. A byte write replaces every writable bit at once. A single-bit access sets or clears one chosen bit. The two bank-select bits sit above a 3-bit register index to form a 5-bit register-file address, so a write to those bits moves every later register access to another bank of eight. Each operation is given for one cycle with a valid strobe, and its results appear on the next clock edge.

Top module: `acc_status_unit`

## Requirements
- R1: After reset the accumulator, the auxiliary register and every stored status bit are 0, so `psw` reads 0x00 and `rf_addr` equals `{2'b00, reg_index}`.
- R2: The status layout from bit 7 down to bit 0 is carry, nibble carry, flag A, bank bit 1, bank bit 0, overflow, flag B, parity. A byte write (`psw_wr`) stores `psw_wdata[7:1]` on the next edge. Its bit 0 has no effect.
- R3: `psw[0]` is 1 exactly when the accumulator holds an odd number of ones, and it follows the accumulator in the same cycle the accumulator changes.
- R4: Op code 0 (add) and op code 1 (add with carry) load `acc + operand (+ carry for code 1)` modulo 256. The carry flag takes the carry out of bit 7. The nibble carry takes the carry out of bit 3.
- R5: Op code 2 (subtract with borrow) loads `acc - operand - carry` modulo 256. The carry flag is set on a borrow out of bit 7. The nibble carry is set on a borrow into bit 3 from bit 4.
- R6: For op codes 0, 1 and 2 the overflow flag is 1 exactly when the signed result is out of range. This means the operands agree in sign on an add, or differ in sign on a subtract, and the result sign differs from the accumulator sign.
- R7: Op code 3 (multiply) puts the low product byte in the accumulator and the high byte in the auxiliary register. It sets overflow exactly when the product exceeds 255, and it clears the carry and the nibble carry.
- R8: Op code 4 (divide) puts the quotient in the accumulator and the remainder in the auxiliary register, and it clears carry, nibble carry and overflow. When the divisor (the auxiliary register) is 0, overflow is set and the accumulator and the auxiliary register keep their values.
- R9: A single-bit write (`bit_wr`) stores `bit_val` into bit `bit_sel` of the status word. A bit-0 target has no effect. When a byte write and a single-bit write come in the same cycle, the single-bit write decides its own bit.
- R10: When an operation and a software status write touch the same bit in one cycle, the software value is stored.
- R11: `rf_addr` is `{bank bit 1, bank bit 0, reg_index}` and takes a new bank on the clock edge that stores the bank bits.
- R12: The operations never change flag A, flag B or the bank bits. Op codes 5 to 7, and any cycle with `op_valid` low, change no register.
- R13: `acc_wr` and `b_wr` load their registers on the next edge. When they come in the same cycle as an operation, they override that operation's result for their own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Start the operation in `op_code` this cycle |
| op_code | input | 3 | 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide, 5-7 none |
| operand | input | 8 | Second operand for add and subtract |
| acc_wr | input | 1 | Load the accumulator from `acc_wdata` |
| acc_wdata | input | 8 | Accumulator load value |
| b_wr | input | 1 | Load the auxiliary register from `b_wdata` |
| b_wdata | input | 8 | Auxiliary register load value |
| psw_wr | input | 1 | Byte write of the status word |
| psw_wdata | input | 8 | Byte write value; bit 0 is not stored |
| bit_wr | input | 1 | Single-bit write of the status word |
| bit_sel | input | 3 | Bit position for the single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| reg_index | input | 3 | Register index inside the selected bank |
| acc | output | 8 | Accumulator |
| b_reg | output | 8 | Auxiliary register (multiply high byte, divide remainder, divisor) |
| psw | output | 8 | Status word |
| rf_addr | output | 5 | Register-file address |

## Verification
Each assertion checks one cycle. It assumes that any strobe which could change the checked bit or register is low in that cycle. For example, the zero-divisor checks require no load of the accumulator or auxiliary register and no software write to the overflow bit. A strobe that does touch the bit takes the assertion out of play rather than breaking it. The stimulus gives most operations on their own, so these checks stay active. It then makes a few deliberate collisions of operation and software write to exercise R10 and R13, and those are checked by the bench's scoreboard model. Invalid op codes are only given with `op_valid` both high and low, never with an unknown value.

// File: rtl/acc_status_pkg.sv
package acc_status_pkg;

  localparam int PSW_W = 8;

  // Bit positions inside the status word (layout is fixed behaviour)
  localparam int POS_CY  = 7;
  localparam int POS_AC  = 6;
  localparam int POS_FA  = 5;
  localparam int POS_RS1 = 4;
  localparam int POS_RS0 = 3;
  localparam int POS_OV  = 2;
  localparam int POS_FB  = 1;
  localparam int POS_PAR = 0;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_ADDC = 3'd1,
    OPC_SUBB = 3'd2,
    OPC_MUL  = 3'd3,
    OPC_DIV  = 3'd4
  } opc_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;

endpackage

// File: rtl/acs_alu_core.sv
module acs_alu_core
  import acc_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              op_fire,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic              cy_in,
  output logic              flag_upd,
  output arith_flags_t      flags,
  output logic              acc_load,
  output logic [DATA_W-1:0] acc_res,
  output logic              b_load,
  output logic [DATA_W-1:0] b_res
);

  localparam int NIB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;
  localparam int PW  = 2 * DATA_W;

  // {carry, nibble carry, overflow, sum}
  function automatic logic [DATA_W+2:0] f_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] x,
                                              input logic cin);
    logic [DATA_W:0] full;
    logic [NIB:0]    low;
    logic            ovf;
    full = {1'b0, a} + {1'b0, x} + {{DATA_W{1'b0}}, cin};
    low  = {1'b0, a[NIB-1:0]} + {1'b0, x[NIB-1:0]} + {{NIB{1'b0}}, cin};
    ovf  = (a[MSB] == x[MSB]) && (full[MSB] != a[MSB]);
    return {full[DATA_W], low[NIB], ovf, full[DATA_W-1:0]};
  endfunction

  // {borrow, nibble borrow, overflow, difference}
  function automatic logic [DATA_W+2:0] f_sub(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] x,
                                              input logic bin);
    logic [DATA_W:0] full;
    logic [NIB:0]    low;
    logic            ovf;
    full = {1'b0, a} - {1'b0, x} - {{DATA_W{1'b0}}, bin};
    low  = {1'b0, a[NIB-1:0]} - {1'b0, x[NIB-1:0]} - {{NIB{1'b0}}, bin};
    ovf  = (a[MSB] != x[MSB]) && (full[MSB] != a[MSB]);
    return {full[DATA_W], low[NIB], ovf, full[DATA_W-1:0]};
  endfunction

  function automatic logic [PW-1:0] f_mul(input logic [DATA_W-1:0] a,
                                          input logic [DATA_W-1:0] b);
    return {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
  endfunction

  logic [DATA_W+2:0] add_v;
  logic [DATA_W+2:0] sub_v;
  logic [PW-1:0]     prod;
  logic              div_zero;

  always_comb begin
    add_v    = f_add(a_in, x_in, (op_code == OPC_ADDC) ? cy_in : 1'b0);
    sub_v    = f_sub(a_in, x_in, cy_in);
    prod     = f_mul(a_in, b_in);
    div_zero = (b_in == '0);

    flag_upd = 1'b0;
    flags    = '0;
    acc_load = 1'b0;
    b_load   = 1'b0;
    acc_res  = a_in;
    b_res    = b_in;

    if (op_fire) begin
      unique case (op_code)
        OPC_ADD, OPC_ADDC: begin
          flag_upd = 1'b1;
          flags    = '{cy: add_v[DATA_W+2], ac: add_v[DATA_W+1], ov: add_v[DATA_W]};
          acc_load = 1'b1;
          acc_res  = add_v[DATA_W-1:0];
        end
        OPC_SUBB: begin
          flag_upd = 1'b1;
          flags    = '{cy: sub_v[DATA_W+2], ac: sub_v[DATA_W+1], ov: sub_v[DATA_W]};
          acc_load = 1'b1;
          acc_res  = sub_v[DATA_W-1:0];
        end
        OPC_MUL: begin
          flag_upd = 1'b1;
          flags    = '{cy: 1'b0, ac: 1'b0, ov: (prod[PW-1:DATA_W] != '0)};
          acc_load = 1'b1;
          b_load   = 1'b1;
          acc_res  = prod[DATA_W-1:0];
          b_res    = prod[PW-1:DATA_W];
        end
        OPC_DIV: begin
          flag_upd = 1'b1;
          flags    = '{cy: 1'b0, ac: 1'b0, ov: div_zero};
          if (!div_zero) begin
            acc_load = 1'b1;
            b_load   = 1'b1;
            acc_res  = a_in / b_in;
            b_res    = a_in % b_in;
          end
        end
        default: begin
          flag_upd = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/acs_data_regs.sv
module acs_data_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_acc_load,
  input  logic [DATA_W-1:0] alu_acc_res,
  input  logic              alu_b_load,
  input  logic [DATA_W-1:0] alu_b_res,
  input  logic              sw_acc_wr,
  input  logic [DATA_W-1:0] sw_acc_data,
  input  logic              sw_b_wr,
  input  logic [DATA_W-1:0] sw_b_data,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] b_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b_q   <= '0;
    end else begin
      if (sw_acc_wr)         acc_q <= sw_acc_data;
      else if (alu_acc_load) acc_q <= alu_acc_res;
      if (sw_b_wr)           b_q   <= sw_b_data;
      else if (alu_b_load)   b_q   <= alu_b_res;
    end
  end

  AST_SW_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc_wr |=> acc_q == $past(sw_acc_data)); // R13

endmodule

// File: rtl/acs_status_reg.sv
module acs_status_reg
  import acc_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_upd,
  input  arith_flags_t      flags,
  input  logic              byte_wr,
  input  logic [PSW_W-1:1]  byte_data,
  input  logic              bit_wr,
  input  logic [2:0]        bit_sel,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] acc_in,
  output logic [PSW_W-1:0]  psw_out
);

  logic [PSW_W-1:1] stat_q;
  logic [PSW_W-1:1] stat_d;
  logic             sw_any;

  assign sw_any = byte_wr || bit_wr;

  always_comb begin
    stat_d = stat_q;
    if (flag_upd) begin
      stat_d[POS_CY] = flags.cy;
      stat_d[POS_AC] = flags.ac;
      stat_d[POS_OV] = flags.ov;
    end
    if (byte_wr) stat_d = byte_data;
    for (int i = 1; i < PSW_W; i++) begin
      if (bit_wr && (bit_sel == 3'(i))) stat_d[i] = bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign psw_out = {stat_q, ^acc_in};

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_upd || sw_any) |=> $stable(stat_q)); // R12

  AST_SW_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !sw_any) |=> (stat_q[POS_FA] == $past(stat_q[POS_FA])) &&
                              (stat_q[POS_FB] == $past(stat_q[POS_FB])) &&
                              (stat_q[POS_RS1:POS_RS0] == $past(stat_q[POS_RS1:POS_RS0]))); // R12

  AST_SW_BEATS_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && bit_wr && bit_sel == 3'(POS_CY)) |=> stat_q[POS_CY] == $past(bit_val)); // R10

endmodule

// File: rtl/acs_bank_addr.sv
module acs_bank_addr #(
  parameter int IDX_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0]       bank_sel,
  input  logic [IDX_W-1:0]        index,
  output logic [BANK_W+IDX_W-1:0] addr
);

  assign addr = {bank_sel, index};

endmodule

// File: rtl/acc_status_unit.sv
module acc_status_unit
  import acc_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [2:0]             op_code,
  input  logic [DATA_W-1:0]      operand,
  input  logic                   acc_wr,
  input  logic [DATA_W-1:0]      acc_wdata,
  input  logic                   b_wr,
  input  logic [DATA_W-1:0]      b_wdata,
  input  logic                   psw_wr,
  input  logic [7:0]             psw_wdata,
  input  logic                   bit_wr,
  input  logic [2:0]             bit_sel,
  input  logic                   bit_val,
  input  logic [IDX_W-1:0]       reg_index,
  output logic [DATA_W-1:0]      acc,
  output logic [DATA_W-1:0]      b_reg,
  output logic [7:0]             psw,
  output logic [IDX_W+1:0]       rf_addr
);

  localparam int BANK_W = POS_RS1 - POS_RS0 + 1;
  localparam int ADDR_W = BANK_W + IDX_W;

  // Named internal events for the assertions
  logic              op_fire;
  logic              flag_upd;
  arith_flags_t      flags;
  logic              alu_acc_load;
  logic              alu_b_load;
  logic [DATA_W-1:0] alu_acc_res;
  logic [DATA_W-1:0] alu_b_res;
  logic              div_zero_ev;
  logic              mul_ev;
  logic              ov_sw_touch;
  logic              par_write_try;
  logic [ADDR_W-1:0] addr_w;

  assign op_fire       = op_valid;
  assign div_zero_ev   = op_fire && (op_code == OPC_DIV) && (b_reg == '0);
  assign mul_ev        = op_fire && (op_code == OPC_MUL);
  assign ov_sw_touch   = psw_wr || (bit_wr && bit_sel == 3'(POS_OV));
  assign par_write_try = psw_wr && (psw_wdata[POS_PAR] != psw[POS_PAR]);

  acs_alu_core #(.DATA_W(DATA_W)) u_alu (
    .op_fire  (op_fire),
    .op_code  (op_code),
    .a_in     (acc),
    .b_in     (b_reg),
    .x_in     (operand),
    .cy_in    (psw[POS_CY]),
    .flag_upd (flag_upd),
    .flags    (flags),
    .acc_load (alu_acc_load),
    .acc_res  (alu_acc_res),
    .b_load   (alu_b_load),
    .b_res    (alu_b_res)
  );

  acs_data_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .alu_acc_load (alu_acc_load),
    .alu_acc_res  (alu_acc_res),
    .alu_b_load   (alu_b_load),
    .alu_b_res    (alu_b_res),
    .sw_acc_wr    (acc_wr),
    .sw_acc_data  (acc_wdata),
    .sw_b_wr      (b_wr),
    .sw_b_data    (b_wdata),
    .acc_q        (acc),
    .b_q          (b_reg)
  );

  acs_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_upd  (flag_upd),
    .flags     (flags),
    .byte_wr   (psw_wr),
    .byte_data (psw_wdata[PSW_W-1:1]),
    .bit_wr    (bit_wr),
    .bit_sel   (bit_sel),
    .bit_val   (bit_val),
    .acc_in    (acc),
    .psw_out   (psw)
  );

  acs_bank_addr #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_bank (
    .bank_sel (psw[POS_RS1:POS_RS0]),
    .index    (reg_index),
    .addr     (addr_w)
  );

  assign rf_addr = addr_w;

  AST_DIV_ZERO_OV: assert property (@(posedge clk) disable iff (!rst_n)
    (div_zero_ev && !ov_sw_touch) |=> psw[POS_OV]); // R8

  AST_DIV_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (div_zero_ev && !acc_wr && !b_wr) |=> $stable(acc) && $stable(b_reg)); // R8

  AST_MUL_OV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_ev && !ov_sw_touch && !b_wr) |=> psw[POS_OV] == (b_reg != '0)); // R7

  AST_BANK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_wr && !bit_wr) |=> rf_addr[ADDR_W-1 -: BANK_W] == $past(psw_wdata[POS_RS1:POS_RS0])); // R11

  AST_PARITY_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (par_write_try && !op_fire && !acc_wr) |=> $stable(psw[POS_PAR])); // R2

endmodule

// File: tb/acc_status_unit_test.sv
`timescale 1ns/1ps
module acc_status_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] operand = 8'h00;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic       b_wr = 1'b0;
  logic [7:0] b_wdata = 8'h00;
  logic       psw_wr = 1'b0;
  logic [7:0] psw_wdata = 8'h00;
  logic       bit_wr = 1'b0;
  logic [2:0] bit_sel = 3'd0;
  logic       bit_val = 1'b0;
  logic [2:0] reg_index = 3'd0;
  logic [7:0] acc;
  logic [7:0] b_reg;
  logic [7:0] psw;
  logic [4:0] rf_addr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] acc;
    logic [7:0] b;
    logic [7:0] psw;
    logic [4:0] rf;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // Bench model state
  logic [7:0] m_acc = 8'h00;
  logic [7:0] m_b   = 8'h00;
  logic [7:0] m_st  = 8'h00; // bit 0 unused

  always #4 clk = ~clk;

  acc_status_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .b_wr(b_wr), .b_wdata(b_wdata), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
    .bit_wr(bit_wr), .bit_sel(bit_sel), .bit_val(bit_val),
    .reg_index(reg_index), .acc(acc), .b_reg(b_reg), .psw(psw), .rf_addr(rf_addr)
  );

  function automatic logic [7:0] exp_psw(input logic [7:0] st, input logic [7:0] a);
    return {st[7:1], logic'($countones(a) % 2)};
  endfunction

  task automatic check_now(input exp_t e);
    checks++;
    if (acc !== e.acc || b_reg !== e.b || psw !== e.psw || rf_addr !== e.rf) begin
      errors++;
      $display("FAIL %s: acc=%h b=%h psw=%h rf=%h expected acc=%h b=%h psw=%h rf=%h",
               e.tag, acc, b_reg, psw, rf_addr, e.acc, e.b, e.psw, e.rf);
    end
  endtask

  // Monitor: compare results one clock after each driven step
  always @(negedge clk) begin
    if (exp_q.size() > 0) check_now(exp_q.pop_front());
  end

  task automatic step(input logic v, input logic [2:0] opc, input logic [7:0] x,
                      input logic aw, input logic [7:0] ad,
                      input logic bw, input logic [7:0] bd,
                      input logic pw, input logic [7:0] pd,
                      input logic sw, input logic [2:0] bs, input logic bv,
                      input logic [2:0] idx, input string tag);
    int a, bb, xx, c, s, r, p;
    logic [7:0] na, nb, ns;
    exp_t e;
    @(negedge clk); #1;
    op_valid = v; op_code = opc; operand = x;
    acc_wr = aw; acc_wdata = ad; b_wr = bw; b_wdata = bd;
    psw_wr = pw; psw_wdata = pd; bit_wr = sw; bit_sel = bs; bit_val = bv;
    reg_index = idx;
    // model
    a = int'(m_acc); bb = int'(m_b); xx = int'(x); c = int'(m_st[7]);
    na = m_acc; nb = m_b; ns = m_st;
    if (v) begin
      case (opc)
        3'd0, 3'd1: begin
          if (opc == 3'd0) c = 0;
          s = a + xx + c; r = s % 256;
          na = 8'(r);
          ns[7] = (s > 255);
          ns[6] = ((a % 16) + (xx % 16) + c) > 15;
          ns[2] = ((a >= 128) == (xx >= 128)) && ((r >= 128) != (a >= 128));
        end
        3'd2: begin
          s = a - xx - c; r = (s + 512) % 256;
          na = 8'(r);
          ns[7] = (s < 0);
          ns[6] = ((a % 16) - (xx % 16) - c) < 0;
          ns[2] = ((a >= 128) != (xx >= 128)) && ((r >= 128) != (a >= 128));
        end
        3'd3: begin
          p = a * bb;
          na = 8'(p % 256); nb = 8'(p / 256);
          ns[7] = 1'b0; ns[6] = 1'b0; ns[2] = (p > 255);
        end
        3'd4: begin
          ns[7] = 1'b0; ns[6] = 1'b0;
          if (bb == 0) ns[2] = 1'b1;
          else begin
            ns[2] = 1'b0; na = 8'(a / bb); nb = 8'(a % bb);
          end
        end
        default: ;
      endcase
    end
    if (aw) na = ad;
    if (bw) nb = bd;
    if (pw) ns[7:1] = pd[7:1];
    if (sw && bs != 3'd0) ns[bs] = bv;
    m_acc = na; m_b = nb; m_st = ns;
    e.acc = na; e.b = nb; e.psw = exp_psw(ns, na); e.rf = {ns[4:3], idx}; e.tag = tag;
    @(posedge clk);
    exp_q.push_back(e);
    #1;
    op_valid = 0; acc_wr = 0; b_wr = 0; psw_wr = 0; bit_wr = 0;
  endtask

  task automatic op(input logic [2:0] opc, input logic [7:0] x, input string tag);
    step(1, opc, x, 0, 0, 0, 0, 0, 0, 0, 0, 0, reg_index, tag);
  endtask
  task automatic ld(input logic [7:0] a, input logic [7:0] b, input string tag);
    step(0, 0, 0, 1, a, 1, b, 0, 0, 0, 0, 0, reg_index, tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    e0.acc = 0; e0.b = 0; e0.psw = 0; e0.rf = 5'd0; e0.tag = "R1 reset";
    check_now(e0);
    rst_n = 1'b1;
    @(negedge clk);
    check_now(e0);

    // R13 load, R3 parity after load
    ld(8'h7F, 8'h00, "R13 load R3 parity");
    op(3'd0, 8'h01, "R4 R6 add signed overflow");
    op(3'd0, 8'h80, "R4 add carry out");
    ld(8'h0F, 8'h00, "R13 load");
    op(3'd0, 8'h01, "R4 nibble carry");
    op(3'd0, 8'hF0, "R4 add");
    op(3'd1, 8'h10, "R4 addc with carry in");
    op(3'd0, 8'hFF, "R4 add wrap");
    op(3'd1, 8'h00, "R4 addc carry only");
    // R5 / R6 subtract
    ld(8'h80, 8'h00, "R13 load");
    op(3'd2, 8'h01, "R5 R6 subb signed overflow");
    ld(8'h00, 8'h00, "R13 load");
    op(3'd2, 8'h01, "R5 subb borrow");
    op(3'd2, 8'h0F, "R5 subb with borrow in");
    op(3'd2, 8'h80, "R6 subb");
    // R7 multiply
    ld(8'h10, 8'h20, "R13 load");
    op(3'd3, 8'h00, "R7 mul wide");
    ld(8'h07, 8'h05, "R13 load");
    op(3'd3, 8'h00, "R7 mul narrow");
    // R8 divide
    ld(8'hC8, 8'h07, "R13 load");
    op(3'd4, 8'h00, "R8 divide");
    ld(8'h55, 8'h00, "R13 load");
    op(3'd4, 8'h00, "R8 divide by zero");
    // R2 byte write, bit 0 ignored
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0, 3'd5, "R2 byte write ones");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h01, 0, 0, 0, 3'd5, "R2 byte write parity only");
    // R9 single bit writes
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd5, 1, 3'd5, "R9 set flag A");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 1, 3'd5, "R9 set flag B");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 0, 3'd5, "R9 bit 0 ignored");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h00, 1, 3'd7, 1, 3'd5, "R9 bit write over byte write");
    // R11 banks
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 0, 0, 0, 0, 1, 8'(k << 3), 0, 0, 0, 3'(k + 2), "R11 bank select");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd4, 0, 3'd6, "R11 bank bit clear");
    // R12 arithmetic keeps software flags
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h3A, 0, 0, 0, 3'd1, "R12 setup");
    ld(8'hFF, 8'h00, "R13 load");
    op(3'd0, 8'h01, "R12 add keeps flag A B banks");
    op(3'd5, 8'h11, "R12 op code 5 no effect");
    op(3'd7, 8'h11, "R12 op code 7 no effect");
    step(0, 3'd0, 8'h11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd1, "R12 valid low no effect");
    // R10 collisions
    ld(8'hFF, 8'h00, "R13 load");
    step(1, 3'd0, 8'h01, 0, 0, 0, 0, 0, 0, 1, 3'd7, 0, 3'd1, "R10 bit write beats carry");
    step(1, 3'd0, 8'h01, 0, 0, 0, 0, 1, 8'h04, 0, 0, 0, 3'd1, "R10 byte write beats flags");
    // R13 load beats op result
    step(1, 3'd0, 8'h22, 1, 8'h5A, 0, 0, 0, 0, 0, 0, 0, 3'd1, "R13 acc load beats add");
    ld(8'h09, 8'h03, "R13 load");
    step(1, 3'd3, 8'h00, 0, 0, 1, 8'hEE, 0, 0, 0, 0, 0, 3'd1, "R13 b load beats mul");
    // Broad mixed run
    for (int n = 0; n < 300; n++) begin
      logic [2:0] oc;
      oc = 3'($urandom_range(0, 4));
      if (n % 9 == 0) ld(8'($urandom), 8'($urandom_range(0, 3)), "R13 mixed load");
      else op(oc, 8'($urandom), "R4 R5 R7 R8 mixed op");
    end
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule